// File: doc/BRIEF.md
# USB Serial Engine Control Register

This block is the byte-wide control and status register that sits beside a small full/low-speed USB serial interface engine, which can act either as host or as device. Software writes it through a simple byte write strobe and reads it back at any time. Reads mix stored control bits with live line conditions from the differential receiver. Event strobes from the engine update the bit that tracks token activity in host mode and transmit suspension in device mode.

The block also owns the per-endpoint ping-pong "odd" bank state: one bit per endpoint direction, toggled by the engine and cleared together by software. It drives the USB line directly when software asks for bus reset or resume signaling. When host-mode resume is released, it appends a low-speed end-of-packet, timed by a programmable bit-time prescaler.

Top module: `usb_ctl_reg`

## Requirements
- R1: After reset every stored bit is 0 and nothing drives the line. Read data is {bit7 J-state, bit6 SE0, bit5 busy/suspend, bit4 bus-reset request, bit3 host enable, bit2 resume request, bit1 always 0, bit0 enable}. A write loads bits 4, 3, 2 and 0 from write data at the clock edge.
- R2: Read bit 6 equals `rx_se0` in the same cycle. Read bit 7 equals `rx_diff` XOR `low_speed` in the same cycle.
- R3: In host mode bit 5 reads token-busy. It becomes 1 the cycle after `tok_start` and 0 the cycle after `tok_done`; `tok_start` wins when both arrive together. Writes to bit 5 have no effect on it.
- R4: In device mode bit 5 reads transmit-suspend. `setup_rx` sets it, and `sie_pause` is high while it is set. A write with bit 5 = 0 clears it and a write with bit 5 = 1 is ignored. `setup_rx` wins over a clearing write in the same cycle.
- R5: While bits 4 and 3 are both stored as 1, the line is driven to SE0 (`drv_en`=1, `drv_dp`=0, `drv_dm`=0). Bit 4 without host mode drives nothing. Bus reset has the highest line priority.
- R6: While bit 2 is stored as 1 and nothing of higher priority is active, the line is driven to K: `drv_dp`=`low_speed`, `drv_dm`=NOT `low_speed`.
- R7: A write that clears bit 2 while bit 2 and bit 3 are stored as 1 starts an end-of-packet on the next cycle: SE0 for 2×(`bit_cyc`+1) cycles, then J (`drv_dp`=NOT `low_speed`, `drv_dm`=`low_speed`) for `bit_cyc`+1 cycles, then release. It ranks above resume and below bus reset. In device mode no end-of-packet follows.
- R8: `odd_tgl` inverts `odd_bits[odd_sel]` on the next cycle and leaves the other bits unchanged. The bit index is endpoint×2 + direction.
- R9: A write with bit 1 = 1 clears all odd bits on the next cycle. This clear wins over a toggle in the same cycle.
- R10: A write that sets bit 0 while it is stored as 0 clears all odd bits, again winning over a same-cycle toggle, and pulses `sie_reset` for exactly one cycle. Writing 1 when bit 0 is already 1 does neither.
- R11: `sof_en` is high exactly when bits 0 and 3 are both stored as 1. `usb_en` follows stored bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data |
| rx_diff | input | 1 | Differential receiver output, 1 when D+ above D- |
| rx_se0 | input | 1 | Live single-ended-zero detect |
| low_speed | input | 1 | Low-speed polarity select |
| bit_cyc | input | DIV_W | Clock cycles per low-speed bit, minus one |
| tok_start | input | 1 | Engine began a token |
| tok_done | input | 1 | Engine finished a token |
| setup_rx | input | 1 | Setup token received |
| odd_tgl | input | 1 | Toggle strobe for one odd bit |
| odd_sel | input | SEL_W | Odd bit index |
| odd_bits | output | ODD_W | Ping-pong odd bank bits |
| usb_en | output | 1 | Engine enable |
| sof_en | output | 1 | Start-of-frame generation enable |
| sie_pause | output | 1 | Device-mode packet handling halted |
| sie_reset | output | 1 | One-cycle engine reset pulse |
| drv_en | output | 1 | Line drive enable |
| drv_dp | output | 1 | D+ drive level |
| drv_dm | output | 1 | D- drive level |

## Verification
Two pairs of functions can land in one cycle. The first is a software clear of the odd bank, either through bit 1 or through an enable rising edge, arriving with an engine toggle strobe. The second is a Setup reception arriving with a software write that clears transmit-suspend. The bench provokes each pair directly by raising both strobes on the same clock edge, and also lets them meet by chance in a long random phase. A per-cycle reference model judges the result: the clear must leave every odd bit at zero, and suspension must remain set.

// File: rtl/usb_ctl_reg.sv
module usb_ctl_reg #(
  parameter int NUM_EP = 16,
  parameter int DIV_W  = 8,
  localparam int ODD_W = 2 * NUM_EP,
  localparam int SEL_W = $clog2(ODD_W)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr,
  input  logic [7:0]       reg_wdata,
  output logic [7:0]       reg_rdata,
  input  logic             rx_diff,
  input  logic             rx_se0,
  input  logic             low_speed,
  input  logic [DIV_W-1:0] bit_cyc,
  input  logic             tok_start,
  input  logic             tok_done,
  input  logic             setup_rx,
  input  logic             odd_tgl,
  input  logic [SEL_W-1:0] odd_sel,
  output logic [ODD_W-1:0] odd_bits,
  output logic             usb_en,
  output logic             sof_en,
  output logic             sie_pause,
  output logic             sie_reset,
  output logic             drv_en,
  output logic             drv_dp,
  output logic             drv_dm
);

  logic rst_q, host_q, res_q, en_q, busy_q, susp_q, sie_q;
  logic [ODD_W-1:0] odd_q;
  logic eop_act;
  logic [DIV_W-1:0] eop_cnt;
  logic [1:0] eop_bit;

  wire odd_clr  = reg_wr & (reg_wdata[1] | (reg_wdata[0] & ~en_q));
  wire eop_go   = reg_wr & res_q & ~reg_wdata[2] & host_q;
  wire susp_set = setup_rx & ~host_q;
  wire susp_clr = reg_wr & ~reg_wdata[5] & ~host_q;
  wire j_dp     = ~low_speed;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_q  <= 1'b0;
      host_q <= 1'b0;
      res_q  <= 1'b0;
      en_q   <= 1'b0;
      sie_q  <= 1'b0;
    end else begin
      sie_q <= reg_wr & reg_wdata[0] & ~en_q;
      if (reg_wr) begin
        rst_q  <= reg_wdata[4];
        host_q <= reg_wdata[3];
        res_q  <= reg_wdata[2];
        en_q   <= reg_wdata[0];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      susp_q <= 1'b0;
    end else begin
      if (tok_start)     busy_q <= 1'b1;
      else if (tok_done) busy_q <= 1'b0;
      if (susp_set)      susp_q <= 1'b1;
      else if (susp_clr) susp_q <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       odd_q <= '0;
    else if (odd_clr) odd_q <= '0;
    else if (odd_tgl) odd_q[odd_sel] <= ~odd_q[odd_sel];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      eop_act <= 1'b0;
      eop_cnt <= '0;
      eop_bit <= '0;
    end else if (eop_go) begin
      eop_act <= 1'b1;
      eop_cnt <= '0;
      eop_bit <= '0;
    end else if (eop_act) begin
      if (eop_cnt == bit_cyc) begin
        eop_cnt <= '0;
        eop_bit <= eop_bit + 2'd1;
        if (eop_bit == 2'd2) eop_act <= 1'b0;
      end else begin
        eop_cnt <= eop_cnt + 1'b1;
      end
    end
  end

  always_comb begin
    drv_en = 1'b0;
    drv_dp = 1'b0;
    drv_dm = 1'b0;
    if (rst_q && host_q) begin
      drv_en = 1'b1;
    end else if (eop_act) begin
      drv_en = 1'b1;
      if (eop_bit == 2'd2) begin
        drv_dp = j_dp;
        drv_dm = ~j_dp;
      end
    end else if (res_q) begin
      drv_en = 1'b1;
      drv_dp = ~j_dp;
      drv_dm = j_dp;
    end
  end

  assign reg_rdata = {rx_diff ^ low_speed, rx_se0, host_q ? busy_q : susp_q,
                      rst_q, host_q, res_q, 1'b0, en_q};
  assign odd_bits  = odd_q;
  assign usb_en    = en_q;
  assign sof_en    = en_q & host_q;
  assign sie_pause = susp_q & ~host_q;
  assign sie_reset = sie_q;

  assert_busy_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
    tok_start && host_q && !(reg_wr && !reg_wdata[3]) |=> reg_rdata[5]);

  assert_susp_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
    setup_rx && !host_q && !(reg_wr && reg_wdata[3]) |=> sie_pause);

  assert_bus_reset_se0_R5: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr && reg_wdata[4] && reg_wdata[3] |=> drv_en && !drv_dp && !drv_dm);

  assert_eop_start_R7: assert property (@(posedge clk) disable iff (!rst_n)
    eop_go && !(reg_wdata[4] && reg_wdata[3]) |=> drv_en && !drv_dp && !drv_dm);

  assert_odd_toggle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    odd_tgl && !odd_clr |=> odd_bits[$past(odd_sel)] != $past(odd_bits[odd_sel]));

  assert_odd_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr && reg_wdata[1] |=> odd_bits == '0);

  assert_sie_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr && reg_wdata[0] && !usb_en |=> sie_reset && usb_en && odd_bits == '0);

  assert_sie_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
    sie_reset |=> !sie_reset);

endmodule

// File: tb/test_usb_ctl_reg.sv
`timescale 1ns/1ps
module test_usb_ctl_reg;
  localparam int NEP = 16;
  localparam int OW  = 2 * NEP;
  localparam int SW  = $clog2(OW);

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n = 1'b0;
  logic reg_wr = 1'b0;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] reg_rdata;
  logic rx_diff = 1'b0, rx_se0 = 1'b0, low_speed = 1'b0;
  logic [7:0] bit_cyc = 8'd2;
  logic tok_start = 1'b0, tok_done = 1'b0, setup_rx = 1'b0, odd_tgl = 1'b0;
  logic [SW-1:0] odd_sel = '0;
  logic [OW-1:0] odd_bits;
  logic usb_en, sof_en, sie_pause, sie_reset, drv_en, drv_dp, drv_dm;

  usb_ctl_reg #(.NUM_EP(NEP), .DIV_W(8)) i_usb_ctl_reg (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .rx_diff(rx_diff), .rx_se0(rx_se0),
    .low_speed(low_speed), .bit_cyc(bit_cyc), .tok_start(tok_start),
    .tok_done(tok_done), .setup_rx(setup_rx), .odd_tgl(odd_tgl),
    .odd_sel(odd_sel), .odd_bits(odd_bits), .usb_en(usb_en), .sof_en(sof_en),
    .sie_pause(sie_pause), .sie_reset(sie_reset), .drv_en(drv_en),
    .drv_dp(drv_dp), .drv_dm(drv_dm));

  // reference model
  bit m_en, m_host, m_rst, m_res, m_busy, m_susp, m_sie;
  bit p_en, p_host, p_res;
  logic [OW-1:0] m_odd;
  int m_eop;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_en = 0; m_host = 0; m_rst = 0; m_res = 0;
      m_busy = 0; m_susp = 0; m_sie = 0; m_odd = '0; m_eop = 0;
    end else begin
      p_en = m_en; p_host = m_host; p_res = m_res;
      m_sie = reg_wr && reg_wdata[0] && !p_en;
      if (reg_wr && p_res && !reg_wdata[2] && p_host) m_eop = 3 * (int'(bit_cyc) + 1);
      else if (m_eop > 0) m_eop = m_eop - 1;
      if (tok_start) m_busy = 1;
      else if (tok_done) m_busy = 0;
      if (setup_rx && !p_host) m_susp = 1;
      else if (reg_wr && !reg_wdata[5] && !p_host) m_susp = 0;
      if (reg_wr && (reg_wdata[1] || (reg_wdata[0] && !p_en))) m_odd = '0;
      else if (odd_tgl) m_odd[odd_sel] = ~m_odd[odd_sel];
      if (reg_wr) begin
        m_rst = reg_wdata[4]; m_host = reg_wdata[3];
        m_res = reg_wdata[2]; m_en = reg_wdata[0];
      end
    end
  end

  int n_run = 0, n_fail = 0;
  bit chk_on = 0, tmo = 0;

  task automatic chk(input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, act, exp, $time);
    end
  endtask

  logic [2:0] e_drv;
  string d_req;
  always @(negedge clk) begin
    #2;
    if (chk_on) begin
      if (m_rst && m_host) begin e_drv = 3'b100; d_req = "R5"; end
      else if (m_eop > 0) begin
        d_req = "R7";
        e_drv = (m_eop > int'(bit_cyc) + 1) ? 3'b100 : {1'b1, ~low_speed, low_speed};
      end else if (m_res) begin e_drv = {1'b1, low_speed, ~low_speed}; d_req = "R6"; end
      else begin e_drv = 3'b000; d_req = "R5"; end
      chk("R2", "live line bits", 64'(reg_rdata[7:6]), 64'({rx_diff ^ low_speed, rx_se0}));
      chk(m_host ? "R3" : "R4", "bit5", 64'(reg_rdata[5]), 64'(m_host ? m_busy : m_susp));
      chk("R1", "stored bits", 64'(reg_rdata[4:0]), 64'({m_rst, m_host, m_res, 1'b0, m_en}));
      chk(d_req, "line drive", 64'({drv_en, drv_dp, drv_dm}), 64'(e_drv));
      chk("R8 R9", "odd bits", 64'(odd_bits), 64'(m_odd));
      chk("R11", "sof/enable", 64'({sof_en, usb_en}), 64'({m_en && m_host, m_en}));
      chk("R4", "pause", 64'(sie_pause), 64'(m_susp && !m_host));
      chk("R10", "sie reset", 64'(sie_reset), 64'(m_sie));
    end
  end

  task automatic tick();
    @(negedge clk);
    reg_wr = 0; tok_start = 0; tok_done = 0; setup_rx = 0; odd_tgl = 0;
  endtask

  task automatic wr(input logic [7:0] d);
    tick();
    reg_wr = 1; reg_wdata = d;
  endtask

  task automatic idle(input int n);
    repeat (n) tick();
  endtask

  task automatic run();
    // R1 reset state and R2 live bits
    idle(3);
    for (int k = 0; k < 8; k++) begin
      tick(); rx_diff = k[0]; rx_se0 = k[1]; low_speed = k[2];
    end
    low_speed = 0;
    // R10 R11 enable in host mode
    wr(8'h09); idle(2); wr(8'h09); idle(2);
    // R3 token busy
    tick(); tok_start = 1; idle(3);
    tick(); tok_done = 1; idle(1);
    tick(); tok_start = 1; tok_done = 1; idle(2);
    wr(8'h29); idle(1);
    tick(); tok_done = 1; idle(1);
    wr(8'h29); idle(2);
    // R5 bus reset
    wr(8'h19); idle(5); wr(8'h09); idle(2);
    wr(8'h11); idle(3); wr(8'h01); idle(2);
    // R6 R7 resume, device then host
    wr(8'h05); idle(4); wr(8'h01); idle(5);
    for (int bc = 0; bc < 2; bc++) begin
      for (int ls = 0; ls < 2; ls++) begin
        bit_cyc = (bc == 0) ? 8'd0 : 8'd3; low_speed = ls[0];
        wr(8'h0D); idle(3); wr(8'h09); idle(3 * (int'(bit_cyc) + 1) + 3);
      end
    end
    bit_cyc = 8'd2; low_speed = 0;
    wr(8'h0D); wr(8'h09); idle(1); wr(8'h19); idle(2); wr(8'h09); idle(12);
    wr(8'h0D); wr(8'h09); tick(); reg_wr = 1; reg_wdata = 8'h0D; idle(14); wr(8'h09); idle(12);
    // R8 R9 odd bank, including clear racing a toggle
    for (int i = 0; i < 10; i++) begin
      tick(); odd_tgl = 1; odd_sel = SW'((i * 7) % OW);
    end
    idle(1); wr(8'h0B); idle(2);
    tick(); odd_tgl = 1; odd_sel = SW'(5); idle(1);
    tick(); odd_tgl = 1; odd_sel = SW'(9); reg_wr = 1; reg_wdata = 8'h0B; idle(2);
    // R10 enable rise clearing odd bits racing a toggle
    wr(8'h08); tick(); odd_tgl = 1; odd_sel = SW'(OW - 1); idle(1);
    tick(); odd_tgl = 1; odd_sel = SW'(2); reg_wr = 1; reg_wdata = 8'h09; idle(2);
    tick(); odd_tgl = 1; odd_sel = SW'(4); reg_wr = 1; reg_wdata = 8'h09; idle(2);
    // R4 device suspend, including setup racing a clear
    wr(8'h01); tick(); setup_rx = 1; idle(2);
    wr(8'h21); idle(1); wr(8'h01); idle(1);
    tick(); setup_rx = 1; idle(1);
    tick(); setup_rx = 1; reg_wr = 1; reg_wdata = 8'h01; idle(2);
    wr(8'h09); tick(); setup_rx = 1; idle(2); wr(8'h01); idle(2);
    // random mix
    bit_cyc = 8'd2;
    for (int c = 0; c < 3000; c++) begin
      tick();
      if ($urandom_range(0, 7) == 0) begin
        reg_wr = 1;
        reg_wdata = (8'($urandom) & 8'hEF) | (($urandom_range(0, 5) == 0) ? 8'h10 : 8'h00);
      end
      tok_start = ($urandom_range(0, 9) == 0);
      tok_done  = ($urandom_range(0, 9) == 0);
      setup_rx  = ($urandom_range(0, 15) == 0);
      odd_tgl   = ($urandom_range(0, 2) == 0);
      odd_sel   = SW'($urandom);
      rx_diff   = 1'($urandom); rx_se0 = 1'($urandom);
      if ($urandom_range(0, 31) == 0) low_speed = ~low_speed;
    end
    idle(20);
  endtask

  initial begin
    @(negedge clk);
    chk_on = 1;
    idle(2);
    rst_n = 1;
    fork
      run();
      begin repeat (150000) @(posedge clk); tmo = 1; end
    join_any
    disable fork;
    if (tmo) $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run + int'(tmo), n_fail + int'(tmo));
    $finish;
  end
endmodule